// File: doc/BRIEF.md
# SD Host Control Register with Card-Detect Logic

This block holds the byte-wide host control register of an SD/MMC host controller, together with the logic that turns its fields into control signals. Software writes and reads the register over a simple single-cycle bus. The fields choose where the card-present state comes from: either the synchronized, active-low card-detect pin or a software test level. They also set the effective data bus width, the kind of DMA engine, the SD clock edge on which CMD and DAT are launched, and the activity LED.

A change in the card-present state sets sticky insertion or removal status bits, each gated by its own enable. Software clears these bits by writing a one to the matching bit through a separate status strobe. Changing the card-detect source counts as a change if it alters the card-present state. Capability, slot type, UHS-II mode and version-4 mode come in as level inputs. No port carries a data stream, so the block has no valid/ready handshake and cannot stall: a register write takes effect on the next clock edge.

Top module: `sd_hostctl_reg`

## Requirements
- R1: Every register field resets to 0. A write with `wr_en` high stores `wdata` on the clock edge, and `rdata` returns the stored byte from the next cycle. The register layout is: bit 7 = source select, bit 6 = test level, bit 5 = 8-bit width, bits 4:3 = DMA select, bit 2 = high-speed, bit 1 = 4-bit width, bit 0 = LED.
- R2: When bit 7 is 0, `card_present` equals the inverted `cd_n_pin` after two clock edges of synchronization. When bit 7 is 1, `card_present` equals bit 6 from the cycle after the write.
- R3: A 0-to-1 change of `card_present` sets `ins_irq` one edge later, but only if `ins_en` is high. A 1-to-0 change sets `rem_irq` one edge later, but only if `rem_en` is high. A disabled change sets nothing.
- R4: The status bits hold until cleared. A `sts_wr` with `sts_wdata` bit 0 (insertion) or bit 1 (removal) set clears the matching bit on the next edge.
- R5: When the slot type is not 2'b10, `bus_width` is coded 0 = 1-bit, 1 = 4-bit, 2 = 8-bit. Bit 5 set gives 2. Otherwise bit 1 set gives 1 and bit 1 clear gives 0.
- R6: When `slot_type` is 2'b10, `bus_width` equals `width_preset`, regardless of bits 5 and 1.
- R7: With `v4_mode` low, `dma_kind` equals DMA select: 0 = SDMA, 1 = 32-bit ADMA1, 2 = 32-bit ADMA2, 3 = 64-bit ADMA2.
- R8: With `v4_mode` high, `dma_kind` is 0 = SDMA, 4 = reserved (select 01), 5 = ADMA2 only (select 10), 6 = ADMA2 or ADMA3 (select 11).
- R9: `dma_rsvd_err` is high exactly when select is 01 with `v4_mode` high, or when select is 11 with `v4_mode` low and `cap_64bit` low.
- R10: `drive_rise` is 1 (launch on the rising SD clock edge) when bit 2 is set, and 0 (launch on the falling edge) when it is clear.
- R11: While `uhs2_mode` is high, bits 2 and 1 have no effect: `drive_rise` is 0, and the width is taken as if bit 1 were clear.
- R12: `led` equals bit 0 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| sts_wr | input | 1 | Status write-one-to-clear strobe |
| sts_wdata | input | 2 | Clear mask: bit 0 insertion, bit 1 removal |
| cd_n_pin | input | 1 | Asynchronous card-detect pin, low = card |
| ins_en | input | 1 | Insertion status enable |
| rem_en | input | 1 | Removal status enable |
| slot_type | input | 2 | Slot type, 2'b10 = shared bus |
| width_preset | input | 2 | Per-device width code for a shared bus |
| uhs2_mode | input | 1 | UHS-II mode active |
| v4_mode | input | 1 | Version-4 host mode |
| cap_64bit | input | 1 | 64-bit addressing capability |
| card_present | output | 1 | Selected card-present state |
| ins_irq | output | 1 | Sticky insertion status |
| rem_irq | output | 1 | Sticky removal status |
| bus_width | output | 2 | Effective width code |
| dma_kind | output | 3 | Decoded DMA engine kind |
| dma_rsvd_err | output | 1 | Reserved or unsupported DMA selection |
| drive_rise | output | 1 | CMD/DAT launched on rising SD clock edge |
| led | output | 1 | Activity LED |

## Verification
A corrupted register bit shows up on `rdata` and on the decoded outputs one cycle after the write, so every register value is written and then read back under all combinations of the mode inputs. A fault in the card-detect path shows up as a wrong `card_present` exactly two edges after a pin change, or as a status bit that appears, disappears or stays missing one edge after that. The bench checks those exact cycles, including the case where only the source select changes.

// File: rtl/sdhc_pkg.sv
package sdhc_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    BW_1 = 2'd0,
    BW_4 = 2'd1,
    BW_8 = 2'd2
  } bw_e;

  typedef enum logic [2:0] {
    DK_SDMA      = 3'd0,
    DK_ADMA1_32  = 3'd1,
    DK_ADMA2_32  = 3'd2,
    DK_ADMA2_64  = 3'd3,
    DK_RSVD      = 3'd4,
    DK_ADMA2     = 3'd5,
    DK_ADMA2_3   = 3'd6
  } dma_e;

  typedef struct packed {
    logic       src_sel;
    logic       test_lvl;
    logic       wide8;
    logic [1:0] dma_sel;
    logic       hs_en;
    logic       wide4;
    logic       led_on;
  } hctl_t;
endpackage

// File: rtl/sdhc_cd_unit.sv
module sdhc_cd_unit #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cd_n_pin,
  input  logic       src_sel,
  input  logic       test_lvl,
  input  logic       ins_en,
  input  logic       rem_en,
  input  logic       clr_wr,
  input  logic [1:0] clr_mask,
  output logic       present,
  output logic       ins_sts,
  output logic       rem_sts
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], cd_n_pin};
  end

  assign present = src_sel ? test_lvl : ~sync_q[SYNC_STAGES-1];
  assign rise    = present & ~prev_q;
  assign fall    = ~present & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      ins_sts <= 1'b0;
      rem_sts <= 1'b0;
    end else begin
      prev_q  <= present;
      ins_sts <= (ins_sts & ~(clr_wr & clr_mask[0])) | (rise & ins_en);
      rem_sts <= (rem_sts & ~(clr_wr & clr_mask[1])) | (fall & rem_en);
    end
  end
endmodule

// File: rtl/sdhc_width_resolve.sv
module sdhc_width_resolve
  import sdhc_pkg::*;
#(
  parameter logic [1:0] SHARED_SLOT = 2'b10
) (
  input  logic       wide8,
  input  logic       wide4,
  input  logic       uhs2,
  input  logic [1:0] slot_type,
  input  logic [1:0] preset,
  output logic [1:0] width
);
  bw_e own_w;
  always_comb begin
    if (wide8)               own_w = BW_8;
    else if (wide4 && !uhs2) own_w = BW_4;
    else                     own_w = BW_1;
    width = (slot_type == SHARED_SLOT) ? preset : own_w;
  end
endmodule

// File: rtl/sdhc_dma_decode.sv
module sdhc_dma_decode
  import sdhc_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       v4,
  input  logic       cap64,
  output logic [2:0] kind,
  output logic       err
);
  dma_e k;
  always_comb begin
    if (v4) begin
      unique case (sel)
        2'b00:   k = DK_SDMA;
        2'b01:   k = DK_RSVD;
        2'b10:   k = DK_ADMA2;
        default: k = DK_ADMA2_3;
      endcase
      err = (sel == 2'b01);
    end else begin
      unique case (sel)
        2'b00:   k = DK_SDMA;
        2'b01:   k = DK_ADMA1_32;
        2'b10:   k = DK_ADMA2_32;
        default: k = DK_ADMA2_64;
      endcase
      err = (sel == 2'b11) && !cap64;
    end
    kind = k;
  end
endmodule

// File: rtl/sd_hostctl_reg.sv
module sd_hostctl_reg
  import sdhc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       sts_wr,
  input  logic [1:0] sts_wdata,
  input  logic       cd_n_pin,
  input  logic       ins_en,
  input  logic       rem_en,
  input  logic [1:0] slot_type,
  input  logic [1:0] width_preset,
  input  logic       uhs2_mode,
  input  logic       v4_mode,
  input  logic       cap_64bit,
  output logic       card_present,
  output logic       ins_irq,
  output logic       rem_irq,
  output logic [1:0] bus_width,
  output logic [2:0] dma_kind,
  output logic       dma_rsvd_err,
  output logic       drive_rise,
  output logic       led
);
  hctl_t ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= hctl_t'(wdata);
  end

  assign rdata      = ctl_q;
  assign led        = ctl_q.led_on;
  assign drive_rise = ctl_q.hs_en & ~uhs2_mode;

  sdhc_cd_unit #(.SYNC_STAGES(SYNC_STAGES)) u_cd (
    .clk(clk), .rst_n(rst_n), .cd_n_pin(cd_n_pin),
    .src_sel(ctl_q.src_sel), .test_lvl(ctl_q.test_lvl),
    .ins_en(ins_en), .rem_en(rem_en),
    .clr_wr(sts_wr), .clr_mask(sts_wdata),
    .present(card_present), .ins_sts(ins_irq), .rem_sts(rem_irq)
  );

  sdhc_width_resolve u_width (
    .wide8(ctl_q.wide8), .wide4(ctl_q.wide4), .uhs2(uhs2_mode),
    .slot_type(slot_type), .preset(width_preset), .width(bus_width)
  );

  sdhc_dma_decode u_dma (
    .sel(ctl_q.dma_sel), .v4(v4_mode), .cap64(cap_64bit),
    .kind(dma_kind), .err(dma_rsvd_err)
  );
endmodule

// File: rtl/sd_hostctl_reg_checks.sv
module sd_hostctl_reg_checks (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rdata,
  input logic       sts_wr,
  input logic [1:0] sts_wdata,
  input logic       ins_en,
  input logic       rem_en,
  input logic [1:0] slot_type,
  input logic [1:0] width_preset,
  input logic       uhs2_mode,
  input logic       v4_mode,
  input logic       ins_irq,
  input logic       rem_irq,
  input logic [1:0] bus_width,
  input logic       dma_rsvd_err,
  input logic       drive_rise,
  input logic       led
);
  assert_ins_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_irq) |-> $past(ins_en));
  assert_rem_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rem_irq) |-> $past(rem_en));
  assert_ins_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_irq && !(sts_wr && sts_wdata[0])) |=> ins_irq);
  assert_rem_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_irq && !(sts_wr && sts_wdata[1])) |=> rem_irq);
  assert_wide8_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_type != 2'b10 && rdata[5]) |-> bus_width == 2'd2);
  assert_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_type == 2'b10) |-> bus_width == width_preset);
  assert_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (v4_mode && rdata[4:3] == 2'b01) |-> dma_rsvd_err);
  assert_uhs_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    uhs2_mode |-> !drive_rise);
  assert_led_R12: assert property (@(posedge clk) disable iff (!rst_n)
    led == rdata[0]);
endmodule

bind sd_hostctl_reg sd_hostctl_reg_checks u_checks (
  .clk(clk), .rst_n(rst_n), .rdata(rdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
  .ins_en(ins_en), .rem_en(rem_en), .slot_type(slot_type), .width_preset(width_preset),
  .uhs2_mode(uhs2_mode), .v4_mode(v4_mode), .ins_irq(ins_irq), .rem_irq(rem_irq),
  .bus_width(bus_width), .dma_rsvd_err(dma_rsvd_err), .drive_rise(drive_rise), .led(led)
);

// File: tb/test_sd_hostctl_reg.sv
module test_sd_hostctl_reg;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, sts_wr = 0, cd_n_pin = 1, ins_en = 0, rem_en = 0;
  logic uhs2_mode = 0, v4_mode = 0, cap_64bit = 0;
  logic [7:0] wdata = 0;
  logic [1:0] sts_wdata = 0, slot_type = 0, width_preset = 0;
  logic [7:0] rdata;
  logic card_present, ins_irq, rem_irq, dma_rsvd_err, drive_rise, led;
  logic [1:0] bus_width;
  logic [2:0] dma_kind;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sd_hostctl_reg i_sd_hostctl_reg (.*);

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1; wdata = v;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic clr(input logic [1:0] m);
    @(negedge clk); sts_wr = 1; sts_wdata = m;
    @(posedge clk); #1; sts_wr = 0; sts_wdata = 0;
  endtask

  function automatic int exp_w(logic [7:0] r, logic [1:0] st, logic [1:0] pre, logic u);
    if (st == 2'b10) return pre;
    if (r[5]) return 2;
    if (r[1] && !u) return 1;
    return 0;
  endfunction

  function automatic int exp_k(logic [1:0] s, logic v4);
    if (!v4) return s;
    return (s == 0) ? 0 : 3 + s;
  endfunction

  function automatic int exp_e(logic [1:0] s, logic v4, logic c);
    return v4 ? (s == 2'b01) : (s == 2'b11 && !c);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(2); rst_n = 1; tick(1);
    chk("R1 reset rdata", rdata, 0);
    chk("R2 reset present", card_present, 0);
    chk("R3 reset ins", ins_irq, 0);
    chk("R3 reset rem", rem_irq, 0);
    chk("R5 reset width", bus_width, 0);
    chk("R7 reset dma", dma_kind, 0);
    chk("R10 reset edge", drive_rise, 0);
    chk("R12 reset led", led, 0);

    // Pin-driven insertion: present after 2 edges, status after 3.
    ins_en = 1; rem_en = 1;
    @(negedge clk); cd_n_pin = 0;
    tick(1); chk("R2 sync not yet", card_present, 0);
    tick(1); chk("R2 pin card in", card_present, 1);
    chk("R3 ins not yet", ins_irq, 0);
    tick(1); chk("R3 ins set", ins_irq, 1);
    tick(3); chk("R4 ins sticky", ins_irq, 1);
    clr(2'b10); chk("R4 wrong mask keeps", ins_irq, 1);
    clr(2'b01); chk("R4 ins cleared", ins_irq, 0);

    // Source switch to test level 0 counts as removal.
    wr(8'h80); chk("R2 test level 0", card_present, 0);
    chk("R3 rem not yet", rem_irq, 0);
    tick(1); chk("R3 rem on switch", rem_irq, 1);
    clr(2'b10); chk("R4 rem cleared", rem_irq, 0);

    // Disabled insertion sets nothing.
    ins_en = 0;
    wr(8'hC0); chk("R2 test level 1", card_present, 1);
    tick(2); chk("R3 ins disabled", ins_irq, 0);
    // Pin ignored while test level selected.
    @(negedge clk); cd_n_pin = 1;
    tick(3); chk("R2 pin ignored", card_present, 1);
    chk("R3 no rem", rem_irq, 0);
    rem_en = 0;

    // Sweep every register value over the mode inputs.
    for (int r = 0; r < 256; r++) begin
      wr(8'(r));
      chk("R1 readback", rdata, r);
      chk("R12 led", led, r & 1);
      for (int m = 0; m < 8; m++) begin
        uhs2_mode = m[0]; v4_mode = m[1]; cap_64bit = m[2];
        for (int st = 0; st < 4; st++) begin
          for (int p = 0; p < 3; p++) begin
            slot_type = 2'(st); width_preset = 2'(p); #1;
            if (st == 2) chk("R6 shared width", bus_width, p);
            else if (m[0]) chk("R11 uhs width", bus_width, exp_w(8'(r), 2'(st), 2'(p), 1'b1));
            else chk("R5 width", bus_width, exp_w(8'(r), 2'(st), 2'(p), 1'b0));
          end
        end
        if (m[1]) chk("R8 dma v4", dma_kind, exp_k(2'(r >> 3), 1'b1));
        else      chk("R7 dma v3", dma_kind, exp_k(2'(r >> 3), 1'b0));
        chk("R9 dma err", dma_rsvd_err, exp_e(2'(r >> 3), m[1], m[2]));
        if (m[0]) chk("R11 uhs edge", drive_rise, 0);
        else      chk("R10 edge", drive_rise, (r >> 2) & 1);
      end
      uhs2_mode = 0; v4_mode = 0; cap_64bit = 0; slot_type = 0; width_preset = 0;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule